// File: doc/BRIEF.md
# Exception Source Priority Resolver

This block sits beside the decode stage of a small RISC core. On every clock it gathers the raw exception requests and picks the one to service. The requests come from two reset kinds, two address-error sources, the floating-point unit, the interrupt lines and the instruction being decoded. It reports the choice one clock later as a one-hot grant vector and as a 4-bit cause code. The core's sequencer then fetches the vector and stacks the state; neither of those is done here.

An undefined opcode is reported as one of two causes. A register remembers whether the last valid instruction was a delayed branch or any other instruction that writes the program counter. An undefined opcode that arrives with that register set is reported as a slot fault. Otherwise it is reported as a general illegal instruction. After each accepted exception the block holds a pending flag until the sequencer acknowledges. While the flag is set it refuses every request except the two reset kinds.

Top module: `exc_prio_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, `cause`, `grant` and `busy` become zero, and the slot-history register is cleared.
- R2: A single accepted request produces, one clock later, its cause code on `cause` and bit (code-1) alone set in `grant`. The codes are: 1 power-on reset, 2 manual reset, 3 CPU address error, 4 DMA address error, 5 FPU fault, 6 NMI, 7 break, 8 debug interrupt, 9 external IRQ, 10 peripheral group, 11 trap, 12 general illegal, 13 slot illegal. A cycle with no accepted request gives cause 0 and an all-zero grant.
- R3: When several requests are accepted in the same cycle, only the one with the smallest code is reported.
- R4: The FPU fault wins over every interrupt source (codes 6 to 10). Trap and both illegal causes lose to every interrupt source.
- R5: An undefined opcode (with `instr_valid`) is reported as code 13 when the previous valid instruction had `pc_write_op` set, and as code 12 otherwise.
- R6: The slot-history register is loaded from `pc_write_op` only in cycles with `instr_valid` high. Cycles without a valid instruction leave it unchanged.
- R7: Any accepted exception clears the slot-history register at the same edge. This takes precedence over loading it.
- R8: An accepted exception sets `busy` one clock later. While `busy` is high, every request with code 3 to 13 is ignored and gives cause 0.
- R9: A cycle with `ack` high and no accepted reset request clears `busy` at that edge.
- R10: Power-on and manual reset requests are accepted even while `busy` is high.
- R11: `trap_op` and `undef_op` have no effect in cycles where `instr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| por_req | input | 1 | Power-on reset request |
| mrst_req | input | 1 | Manual reset request |
| cpu_adr_err | input | 1 | Address error from a CPU access |
| dma_adr_err | input | 1 | Address error from a DMA access |
| fpu_exc | input | 1 | Floating-point fault |
| nmi_req | input | 1 | Non-maskable interrupt |
| brk_req | input | 1 | Break-condition interrupt |
| dbg_req | input | 1 | Debug-port interrupt |
| irq_req | input | 1 | External interrupt line, already level-qualified |
| periph_req | input | 1 | Aggregated on-chip peripheral interrupt |
| instr_valid | input | 1 | Decode stage holds a valid instruction this cycle |
| trap_op | input | 1 | Decoded instruction is a trap |
| undef_op | input | 1 | Decoded opcode is undefined |
| pc_write_op | input | 1 | Decoded instruction is a delayed branch or otherwise writes the PC |
| ack | input | 1 | Sequencer acknowledges the reported exception |
| grant | output | 13 | Registered one-hot grant, bit (code-1) |
| cause | output | 4 | Registered cause code, 0 when none |
| busy | output | 1 | Acknowledge-pending flag |

## Verification
Two functions can fall in the same cycle. The first is the loading of the slot-history register by a valid PC-writing instruction. The second is the clearing of that register when an exception is accepted. The bench raises NMI together with a valid PC-writing instruction, acknowledges, and then sends an undefined opcode; the correct outcome is code 12, not 13. A second collision is a reset request that arrives while `busy` is high. It must still be reported, while a lower request in the same cycle must stay hidden. The bench provokes this on purpose and judges it by the cause code seen one clock later.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

    // Number of distinct exception causes and width of the encoded cause.
    localparam int unsigned SRC_N  = 13;
    localparam int unsigned CODE_W = 4;

    // Source indices in descending priority order (index 0 highest).
    localparam int unsigned IX_POR    = 0;
    localparam int unsigned IX_MRST   = 1;
    localparam int unsigned IX_CPU_AE = 2;
    localparam int unsigned IX_DMA_AE = 3;
    localparam int unsigned IX_FPU    = 4;
    localparam int unsigned IX_NMI    = 5;
    localparam int unsigned IX_BRK    = 6;
    localparam int unsigned IX_DBG    = 7;
    localparam int unsigned IX_IRQ    = 8;
    localparam int unsigned IX_PERIPH = 9;
    localparam int unsigned IX_TRAP   = 10;
    localparam int unsigned IX_ILL    = 11;
    localparam int unsigned IX_SLOT   = 12;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE   = 4'd0,
        EXC_POR    = 4'd1,
        EXC_MRST   = 4'd2,
        EXC_CPU_AE = 4'd3,
        EXC_DMA_AE = 4'd4,
        EXC_FPU    = 4'd5,
        EXC_NMI    = 4'd6,
        EXC_BRK    = 4'd7,
        EXC_DBG    = 4'd8,
        EXC_IRQ    = 4'd9,
        EXC_PERIPH = 4'd10,
        EXC_TRAP   = 4'd11,
        EXC_ILL    = 4'd12,
        EXC_SLOT   = 4'd13
    } exc_code_e;

    // Requests that are not tied to the instruction stream.
    typedef struct packed {
        logic por;
        logic mrst;
        logic cpu_ae;
        logic dma_ae;
        logic fpu;
        logic nmi;
        logic brk;
        logic dbg;
        logic irq;
        logic periph;
    } async_req_t;

    // Outcome of one arbitration round.
    typedef struct packed {
        logic      taken;
        src_vec_t  onehot;
        exc_code_e code;
    } pick_t;

    // Bits that bypass the acknowledge-pending gate.
    localparam src_vec_t RESET_BITS = src_vec_t'((1 << IX_POR) | (1 << IX_MRST));

    // Encode a one-hot vector into its cause code (index + 1).
    function automatic exc_code_e code_of(input src_vec_t oh);
        exc_code_e c;
        c = EXC_NONE;
        for (int i = 0; i < int'(SRC_N); i++) begin
            if (oh[i]) c = exc_code_e'(CODE_W'(i + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/exc_slot_tracker.sv
module exc_slot_tracker (
    input  logic clk,
    input  logic rst,
    input  logic instr_valid,
    input  logic pc_write_op,
    input  logic taken,
    output logic slot_flag
);

    logic flag_q;

    // An accepted exception flushes the history; otherwise valid
    // instructions load it and bubbles hold it.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (taken) begin
            flag_q <= 1'b0;
        end else if (instr_valid) begin
            flag_q <= pc_write_op;
        end
    end

    assign slot_flag = flag_q;

    // R6: bubbles without an exception keep the history
    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid && !taken) |=> $stable(slot_flag));

    // R7: an accepted exception leaves the history cleared
    assert_flag_flush_R7: assert property (@(posedge clk) disable iff (rst)
        taken |=> !slot_flag);

endmodule

// File: rtl/exc_req_gather.sv
module exc_req_gather
    import exc_prio_pkg::*;
(
    input  async_req_t areq,
    input  logic       instr_valid,
    input  logic       trap_op,
    input  logic       undef_op,
    input  logic       slot_flag,
    input  logic       busy,
    output src_vec_t   req
);

    src_vec_t raw;
    logic     undef_hit;
    logic     trap_hit;

    // Instruction-borne faults count only when decode holds a valid word.
    assign undef_hit = instr_valid & undef_op;
    assign trap_hit  = instr_valid & trap_op;

    always_comb begin
        raw            = '0;
        raw[IX_POR]    = areq.por;
        raw[IX_MRST]   = areq.mrst;
        raw[IX_CPU_AE] = areq.cpu_ae;
        raw[IX_DMA_AE] = areq.dma_ae;
        raw[IX_FPU]    = areq.fpu;
        raw[IX_NMI]    = areq.nmi;
        raw[IX_BRK]    = areq.brk;
        raw[IX_DBG]    = areq.dbg;
        raw[IX_IRQ]    = areq.irq;
        raw[IX_PERIPH] = areq.periph;
        raw[IX_TRAP]   = trap_hit;
        // Split the undefined opcode by the slot history.
        raw[IX_ILL]    = undef_hit & ~slot_flag;
        raw[IX_SLOT]   = undef_hit &  slot_flag;
    end

    // While waiting for acknowledge only the reset kinds pass.
    assign req = busy ? (raw & RESET_BITS) : raw;

    // R5: an undefined opcode never raises both illegal kinds at once
    always_comb begin
        assert_ill_split_R5: assert (!(raw[IX_ILL] && raw[IX_SLOT]));
    end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_prio_pkg::*;
(
    input  src_vec_t req,
    output pick_t    pick
);

    // seen[i] is set when any source above index i requests.
    src_vec_t seen;
    src_vec_t win;

    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < int'(SRC_N); gi++) begin : g_chain
            assign win[gi] = req[gi] & ~seen[gi];
            if (gi + 1 < int'(SRC_N)) begin : g_next
                assign seen[gi+1] = seen[gi] | req[gi];
            end
        end
    endgenerate

    always_comb begin
        pick.taken  = |req;
        pick.onehot = win;
        pick.code   = code_of(win);
    end

    // R3: exactly one winner whenever something requests
    always_comb begin
        assert_single_winner_R3: assert ((|req) ? $onehot(win) : (win == '0));
    end

endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
    import exc_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                por_req,
    input  logic                mrst_req,
    input  logic                cpu_adr_err,
    input  logic                dma_adr_err,
    input  logic                fpu_exc,
    input  logic                nmi_req,
    input  logic                brk_req,
    input  logic                dbg_req,
    input  logic                irq_req,
    input  logic                periph_req,
    input  logic                instr_valid,
    input  logic                trap_op,
    input  logic                undef_op,
    input  logic                pc_write_op,
    input  logic                ack,
    output logic [SRC_N-1:0]    grant,
    output logic [CODE_W-1:0]   cause,
    output logic                busy
);

    async_req_t areq;
    src_vec_t   req;
    pick_t      pick;
    logic       slot_flag;
    logic       busy_q;
    src_vec_t   grant_q;
    exc_code_e  cause_q;

    always_comb begin
        areq.por    = por_req;
        areq.mrst   = mrst_req;
        areq.cpu_ae = cpu_adr_err;
        areq.dma_ae = dma_adr_err;
        areq.fpu    = fpu_exc;
        areq.nmi    = nmi_req;
        areq.brk    = brk_req;
        areq.dbg    = dbg_req;
        areq.irq    = irq_req;
        areq.periph = periph_req;
    end

    exc_slot_tracker u_track (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .pc_write_op (pc_write_op),
        .taken       (pick.taken),
        .slot_flag   (slot_flag)
    );

    exc_req_gather u_gather (
        .areq        (areq),
        .instr_valid (instr_valid),
        .trap_op     (trap_op),
        .undef_op    (undef_op),
        .slot_flag   (slot_flag),
        .busy        (busy_q),
        .req         (req)
    );

    exc_prio_pick u_pick (
        .req  (req),
        .pick (pick)
    );

    // Registered report and acknowledge-pending flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            cause_q <= EXC_NONE;
            busy_q  <= 1'b0;
        end else begin
            grant_q <= pick.onehot;
            cause_q <= pick.code;
            if (pick.taken) begin
                busy_q <= 1'b1;
            end else if (ack) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign grant = grant_q;
    assign cause = cause_q;
    assign busy  = busy_q;

    // R2: grant and cause always agree
    assert_grant_code_R2: assert property (@(posedge clk) disable iff (rst)
        (cause != 4'd0) |-> (grant == (SRC_N'(1) << (cause - 4'd1))));

    assert_grant_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (cause == 4'd0) |-> (grant == '0));

    // R8: a report sets the pending flag
    assert_report_sets_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> busy);

    // R8: nothing but resets gets through while pending
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !por_req && !mrst_req) |=> (cause == 4'd0));

    // R9: acknowledge releases the pending flag
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && ack && !por_req && !mrst_req) |=> !busy);

    // R10: power-on reset request is always honoured
    assert_por_wins_R10: assert property (@(posedge clk) disable iff (rst)
        por_req |=> (cause == 4'd1));

endmodule

// File: tb/exc_prio_resolver_bench.sv
module exc_prio_resolver_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  asrc;      // bit 0 power-on .. bit 9 peripheral
    logic        instr_valid, trap_op, undef_op, pc_write_op, ack;
    logic [12:0] grant;
    logic [3:0]  cause;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    exc_prio_resolver u_exc_prio_resolver (
        .clk         (clk),
        .rst         (rst),
        .por_req     (asrc[0]),
        .mrst_req    (asrc[1]),
        .cpu_adr_err (asrc[2]),
        .dma_adr_err (asrc[3]),
        .fpu_exc     (asrc[4]),
        .nmi_req     (asrc[5]),
        .brk_req     (asrc[6]),
        .dbg_req     (asrc[7]),
        .irq_req     (asrc[8]),
        .periph_req  (asrc[9]),
        .instr_valid (instr_valid),
        .trap_op     (trap_op),
        .undef_op    (undef_op),
        .pc_write_op (pc_write_op),
        .ack         (ack),
        .grant       (grant),
        .cause       (cause),
        .busy        (busy)
    );

    function automatic logic [12:0] oh_of(input int c);
        return (c == 0) ? 13'd0 : (13'd1 << (c - 1));
    endfunction

    // Compare cause and grant against an expected code.
    task automatic chk_code(input string req, input int exp);
        n_chk++;
        if (cause !== 4'(exp) || grant !== oh_of(exp)) begin
            n_fail++;
            $display("FAIL %s: cause=%0d grant=%013b expected cause=%0d grant=%013b",
                     req, cause, grant, exp, oh_of(exp));
        end
    endtask

    task automatic chk_busy(input string req, input logic exp);
        n_chk++;
        if (busy !== exp) begin
            n_fail++;
            $display("FAIL %s: busy=%0b expected %0b", req, busy, exp);
        end
    endtask

    // Apply one request cycle, then return to idle; outputs are then valid.
    task automatic step(input logic [9:0] a, input logic iv, input logic tr,
                        input logic un, input logic pw);
        asrc = a; instr_valid = iv; trap_op = tr; undef_op = un; pc_write_op = pw;
        @(negedge clk);
        asrc = '0; instr_valid = 0; trap_op = 0; undef_op = 0; pc_write_op = 0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset();   // R1
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_code("R1", 0);
        chk_busy("R1", 1'b0);
    endtask

    task automatic t_singles();   // R2
        for (int i = 0; i < 10; i++) begin
            step(10'(1 << i), 0, 0, 0, 0);
            chk_code("R2", i + 1);
            chk_busy("R2", 1'b1);
            do_ack();
        end
        step('0, 1, 1, 0, 0);
        chk_code("R2 trap", 11);
        do_ack();
        step('0, 1, 0, 1, 0);
        chk_code("R2 illegal", 12);
        do_ack();
        step('0, 0, 0, 0, 0);
        chk_code("R2 idle", 0);
    endtask

    task automatic t_pairs();   // R3
        for (int i = 0; i < 10; i++) begin
            for (int j = i + 1; j < 10; j++) begin
                step(10'((1 << i) | (1 << j)), 0, 0, 0, 0);
                chk_code("R3", i + 1);
                do_ack();
            end
        end
        step(10'h3FF, 1, 0, 1, 0);
        chk_code("R3 all", 1);
        do_ack();
    endtask

    task automatic t_mixed_order();   // R4
        step(10'h3E0 | 10'h010, 0, 0, 0, 0);
        chk_code("R4 fpu over interrupts", 5);
        do_ack();
        step(10'h200, 1, 1, 0, 0);
        chk_code("R4 periph over trap", 10);
        do_ack();
        step(10'h100, 1, 0, 1, 0);
        chk_code("R4 irq over illegal", 9);
        do_ack();
        step(10'h020, 1, 1, 0, 0);
        chk_code("R4 nmi over trap", 6);
        do_ack();
    endtask

    task automatic t_slot();   // R5
        step('0, 1, 0, 0, 1);
        chk_code("R5 branch no fault", 0);
        step('0, 1, 0, 1, 0);
        chk_code("R5 slot", 13);
        do_ack();
        step('0, 1, 0, 0, 0);
        step('0, 1, 0, 1, 0);
        chk_code("R5 general", 12);
        do_ack();
    endtask

    task automatic t_hold();   // R6
        step('0, 1, 0, 0, 1);
        step('0, 0, 0, 0, 0);
        step('0, 0, 0, 0, 0);
        step('0, 1, 0, 1, 0);
        chk_code("R6 held across bubbles", 13);
        do_ack();
        // Invalid cycle with pc_write_op must not load the history.
        step('0, 1, 0, 0, 0);
        step('0, 0, 0, 0, 1);
        step('0, 1, 0, 1, 0);
        chk_code("R6 invalid no load", 12);
        do_ack();
    endtask

    task automatic t_flush();   // R7
        step(10'h020, 1, 0, 0, 1);
        chk_code("R7 nmi taken", 6);
        do_ack();
        step('0, 1, 0, 1, 0);
        chk_code("R7 history flushed", 12);
        do_ack();
    endtask

    task automatic t_busy();   // R8, R9
        step(10'h100, 0, 0, 0, 0);
        chk_code("R8", 9);
        chk_busy("R8", 1'b1);
        step(10'h024, 1, 1, 0, 0);
        chk_code("R8 ignored", 0);
        chk_busy("R8 still pending", 1'b1);
        do_ack();
        chk_busy("R9", 1'b0);
        step(10'h004, 0, 0, 0, 0);
        chk_code("R9 accepts again", 3);
        do_ack();
    endtask

    task automatic t_reset_override();   // R10
        step(10'h200, 0, 0, 0, 0);
        chk_busy("R10 setup", 1'b1);
        step(10'h012, 0, 0, 0, 0);
        chk_code("R10 manual reset while busy", 2);
        step(10'h001, 0, 0, 0, 0);
        chk_code("R10 power-on while busy", 1);
        do_ack();
    endtask

    task automatic t_invalid();   // R11
        step('0, 0, 1, 0, 0);
        chk_code("R11 trap ignored", 0);
        chk_busy("R11", 1'b0);
        step('0, 0, 0, 1, 0);
        chk_code("R11 undef ignored", 0);
        chk_busy("R11", 1'b0);
    endtask

    initial begin
        rst = 1'b1; asrc = '0; instr_valid = 0; trap_op = 0; undef_op = 0;
        pc_write_op = 0; ack = 0;
        @(negedge clk);
        t_reset();
        t_singles();
        t_pairs();
        t_mixed_order();
        t_slot();
        t_hold();
        t_flush();
        t_busy();
        t_reset_override();
        t_invalid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule